// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block sequences master-mode I2C transfers at byte level. Software writes a control word, a slave address and a byte count through a small register port, then loads or drains a four-byte data buffer through a 16-bit data register. When a start is requested with master mode on, the sequencer runs an address phase to the slave, then moves data bytes between the buffer and a byte-handshake bus port. It ends either with a stop phase or by raising access-ready and leaving the bus held. Bit timing on the wires is outside this block. A separate byte-level bus engine serves `bus_req` and answers with a one-cycle `bus_done` and an acknowledge result.

Two modes exist. In count mode a transfer length limits the data phase. In repeat mode the length is ignored, and the data phase runs until the buffer is empty (transmit) or full (receive). The hardware clears the start, stop and master bits itself. After a stop phase it reloads the remaining count from the programmed length. Any host data access, and any control write while the bus is held, makes the sequencer evaluate again, so a parked transfer continues once software has refilled or drained the buffer.

Register map (3-bit address): 0 control, 1 slave address, 2 count (a write sets the programmed length, a read returns the remaining count), 3 data, 4 status (write 1 to clear).

Top module: `i2c_xfer_seq`

## Requirements
- R1: A control write stores only the bits in mask 0xCF07. The bits used are: 0 start, 1 stop request, 2 repeat mode, 9 transmit, 10 master, 14 byte swap, 15 enable.
- R2: A control write with bit 15 clear returns control, slave address, programmed and remaining count, status and data buffer to zero. Reset does the same.
- R3: With enable, master and start set, an address phase runs. It raises `bus_start`, and `bus_wbyte` is the slave address bits 6:0 followed by the inverse of the transmit bit as bit 0. The start bit then reads back as 0. Start without master issues no bus request.
- R4: A NACK to the address sets status bit 0, clears the stop request, moves no data and releases the bus (status bit 4, bus held, reads 0).
- R5: In count mode each data byte decrements the remaining count. Transmit sends bytes in buffer order and stops when the buffer is empty, setting status bit 3 (transmit-ready). The count register read returns the remaining count.
- R6: When the remaining count is zero and stop is requested, a stop phase runs (`bus_stop`), the stop bit clears and the remaining count reloads from the programmed length. Without a stop request, status bit 1 (access-ready) sets, the master bit clears and the bus stays held.
- R7: A NACK on a transmitted data byte sets status bit 0, clears the stop request and sends no further bytes.
- R8: Receive in count mode takes bytes until the count is zero or four bytes are buffered, and sets status bit 2 (receive-ready).
- R9: In repeat mode the count is not decremented. Transmit drains the buffer and then sets transmit-ready. Receive fills the buffer to four bytes. A stop request ends the transfer.
- R10: A data write appends two bytes, the low byte first, or the high byte first when bit 14 is set. A data read returns the two oldest bytes: the oldest in bits 7:0, or in bits 15:8 when bit 14 is set. A read that finds one byte returns 0 in the other half and sets status bit 5.
- R11: A data write is ignored while the buffer holds more than two bytes.
- R12: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data reads pop the buffer) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the strobe cycle |
| bus_req | output | 1 | Bus phase request, held until `bus_done` |
| bus_start | output | 1 | Requested phase is a start plus address byte |
| bus_stop | output | 1 | Requested phase is a stop |
| bus_rd | output | 1 | Requested phase receives a data byte |
| bus_wbyte | output | 8 | Address or data byte to send |
| bus_done | input | 1 | One-cycle completion of the requested phase |
| bus_nack | input | 1 | Byte was not acknowledged (valid with `bus_done`) |
| bus_rbyte | input | 8 | Received byte (valid with `bus_done`) |

## Verification
The hardest situation to reach is a transfer parked halfway, then resumed. In count mode a receive that fills the buffer before the count runs out must continue only after the host drains data, and then finish with access-ready. The bench sets up a length of six with a four-byte buffer and reads the data back between the two bursts. It also exercises a data NACK in the middle of a burst, an overfilled transmit buffer, and repeat mode ended by a later stop write. Seeded random count-mode transfers cover the remaining combinations of length, fill level and stop request.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int REG_W  = 16;
    localparam int REG_AW = 3;
    localparam int BYTE_W = 8;
    localparam int STAT_W = 6;

    localparam logic [REG_W-1:0] CTRL_KEEP = 16'hCF07;

    // control bit positions
    localparam int C_START = 0;
    localparam int C_STOP  = 1;
    localparam int C_RPT   = 2;
    localparam int C_TX    = 9;
    localparam int C_MST   = 10;
    localparam int C_SWAP  = 14;
    localparam int C_EN    = 15;

    // status bit positions
    localparam int S_NACK   = 0;
    localparam int S_ARDY   = 1;
    localparam int S_RRDY   = 2;
    localparam int S_XRDY   = 3;
    localparam int S_BUSY   = 4;
    localparam int S_SINGLE = 5;

    localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] A_SADDR = 3'd1;
    localparam logic [REG_AW-1:0] A_COUNT = 3'd2;
    localparam logic [REG_AW-1:0] A_DATA  = 3'd3;
    localparam logic [REG_AW-1:0] A_STAT  = 3'd4;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_ADDR, SQ_EVAL, SQ_XFER, SQ_STOP, SQ_PARK
    } sq_state_e;

    typedef struct packed {
        logic set_nack;
        logic set_ardy;
        logic set_rrdy;
        logic set_xrdy;
        logic clr_start;
        logic clr_stop;
        logic clr_mst;
    } sq_evt_t;

    function automatic logic [BYTE_W-1:0] addr_byte(input logic [6:0] sa, input logic tx);
        return {sa, ~tx};
    endfunction
endpackage

// File: rtl/i2cs_bytebuf.sv
module i2cs_bytebuf #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          bus_pop,
    input  logic          bus_push,
    input  logic [W-1:0]  bus_byte,
    input  logic          host_pop,
    input  logic          host_push,
    input  logic [W-1:0]  host_b0,
    input  logic [W-1:0]  host_b1,
    output logic [LW-1:0] level,
    output logic [W-1:0]  head0,
    output logic [W-1:0]  head1
);
    localparam logic [LW-1:0] FULL  = LW'(DEPTH);
    localparam logic [LW-1:0] ROOM2 = LW'(DEPTH - 2);

    logic [W-1:0]  q  [DEPTH];
    logic [W-1:0]  nq [DEPTH];
    logic [LW-1:0] nl;

    always_comb begin
        nq = q;
        nl = level;
        if (clr) begin
            nl = '0;
        end else begin
            // bus side first, then host side, so same-cycle events compose
            if (bus_pop && nl != '0) begin
                for (int i = 0; i < DEPTH - 1; i++) nq[i] = nq[i+1];
                nl = nl - 1'b1;
            end
            if (bus_push && nl < FULL) begin
                for (int i = 0; i < DEPTH; i++)
                    if (LW'(i) == nl) nq[i] = bus_byte;
                nl = nl + 1'b1;
            end
            if (host_pop) begin
                for (int s = 0; s < 2; s++) begin
                    if (nl != '0) begin
                        for (int i = 0; i < DEPTH - 1; i++) nq[i] = nq[i+1];
                        nl = nl - 1'b1;
                    end
                end
            end
            if (host_push && nl <= ROOM2) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (LW'(i) == nl)        nq[i] = host_b0;
                    if (LW'(i) == nl + 1'b1) nq[i] = host_b1;
                end
                nl = nl + LW'(2);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
            for (int i = 0; i < DEPTH; i++) q[i] <= '0;
        end else begin
            level <= nl;
            q     <= nq;
        end
    end

    assign head0 = q[0];
    assign head1 = q[1];
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine import i2cs_pkg::*; #(
    parameter int CNT_W = 16,
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_clr,
    input  logic              en,
    input  logic              mst,
    input  logic              start,
    input  logic              stop,
    input  logic              rpt,
    input  logic              tx,
    input  logic              kick,
    input  logic [BYTE_W-1:0] abyte,
    input  logic [CNT_W-1:0]  prog_cnt,
    input  logic [LW-1:0]     level,
    input  logic [BYTE_W-1:0] head,
    input  logic              bus_done,
    input  logic              bus_nack,
    output logic              bus_req,
    output logic              bus_start,
    output logic              bus_stop,
    output logic              bus_rd,
    output logic [BYTE_W-1:0] bus_wbyte,
    output logic              buf_pop,
    output logic              buf_push,
    output sq_evt_t           evt,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              busy
);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    sq_state_e        st, nst;
    logic [CNT_W-1:0] ncnt;
    logic             move_ok;
    logic             go;

    assign move_ok = tx ? (level != '0) : (level != FULL);
    assign go      = en && mst && start;

    always_comb begin
        nst       = st;
        ncnt      = cur_cnt;
        evt       = '0;
        bus_req   = 1'b0;
        bus_start = 1'b0;
        bus_stop  = 1'b0;
        bus_rd    = 1'b0;
        bus_wbyte = '0;
        buf_pop   = 1'b0;
        buf_push  = 1'b0;
        unique case (st)
            SQ_IDLE, SQ_PARK: begin
                if (go) begin
                    evt.clr_start = 1'b1;
                    ncnt          = prog_cnt;
                    nst           = SQ_ADDR;
                end else if (st == SQ_PARK && kick) begin
                    nst = SQ_EVAL;
                end
            end
            SQ_ADDR: begin
                bus_req   = 1'b1;
                bus_start = 1'b1;
                bus_wbyte = abyte;
                if (bus_done) begin
                    if (bus_nack) begin
                        evt.set_nack = 1'b1;
                        evt.clr_stop = 1'b1;
                        nst          = SQ_IDLE;
                    end else begin
                        nst = SQ_EVAL;
                    end
                end
            end
            SQ_EVAL: begin
                if (!rpt && cur_cnt == '0) begin
                    if (stop) nst = SQ_STOP;
                    else begin
                        evt.set_ardy = 1'b1;
                        evt.clr_mst  = 1'b1;
                        nst          = SQ_PARK;
                    end
                end else if (rpt && stop) begin
                    nst = SQ_STOP;
                end else if (move_ok) begin
                    nst = SQ_XFER;
                end else begin
                    evt.set_xrdy = tx;
                    evt.set_rrdy = !tx;
                    nst          = SQ_PARK;
                end
            end
            SQ_XFER: begin
                bus_req   = 1'b1;
                bus_rd    = !tx;
                bus_wbyte = tx ? head : '0;
                if (bus_done) begin
                    if (!rpt) ncnt = cur_cnt - CNT_W'(1);
                    if (tx) begin
                        buf_pop = 1'b1;
                        if (bus_nack) begin
                            evt.set_nack = 1'b1;
                            evt.clr_stop = 1'b1;
                            nst          = SQ_PARK;
                        end else begin
                            nst = SQ_EVAL;
                        end
                    end else begin
                        buf_push     = 1'b1;
                        evt.set_rrdy = 1'b1;
                        nst          = SQ_EVAL;
                    end
                end
            end
            SQ_STOP: begin
                bus_req  = 1'b1;
                bus_stop = 1'b1;
                if (bus_done) begin
                    evt.clr_stop = 1'b1;
                    ncnt         = prog_cnt;
                    nst          = SQ_IDLE;
                end
            end
            default: nst = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            st      <= SQ_IDLE;
            cur_cnt <= '0;
        end else begin
            st      <= nst;
            cur_cnt <= ncnt;
        end
    end

    assign busy = (st != SQ_IDLE);
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq import i2cs_pkg::*; #(
    parameter int CNT_W     = 16,
    parameter int BUF_DEPTH = 4,
    parameter int SADDR_W   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              bus_req,
    output logic              bus_start,
    output logic              bus_stop,
    output logic              bus_rd,
    output logic [BYTE_W-1:0] bus_wbyte,
    input  logic              bus_done,
    input  logic              bus_nack,
    input  logic [BYTE_W-1:0] bus_rbyte
);
    localparam int LVL_W = $clog2(BUF_DEPTH + 1);

    logic [REG_W-1:0]   ctrl;
    logic [SADDR_W-1:0] saddr;
    logic [CNT_W-1:0]   cnt_prog;
    logic [CNT_W-1:0]   cur_cnt;
    logic [STAT_W-1:0]  stat;
    logic [STAT_W-1:0]  stat_view;
    logic [LVL_W-1:0]   level;
    logic [BYTE_W-1:0]  head0, head1, hi_b, b0, b1;
    logic               wr_ctrl, soft_clr, data_wr, data_rd, stat_wr, kick, busy;
    logic               buf_pop, buf_push;
    sq_evt_t            evt;

    assign wr_ctrl  = reg_wr && reg_addr == A_CTRL;
    assign soft_clr = wr_ctrl && !reg_wdata[C_EN];
    assign data_wr  = reg_wr && reg_addr == A_DATA;
    assign data_rd  = reg_rd && reg_addr == A_DATA;
    assign stat_wr  = reg_wr && reg_addr == A_STAT;
    assign kick     = data_wr || data_rd || wr_ctrl;

    assign b0 = ctrl[C_SWAP] ? reg_wdata[15:8] : reg_wdata[7:0];
    assign b1 = ctrl[C_SWAP] ? reg_wdata[7:0]  : reg_wdata[15:8];

    i2cs_bytebuf #(.DEPTH(BUF_DEPTH), .W(BYTE_W)) u_buf (
        .clk(clk), .rst(rst), .clr(soft_clr),
        .bus_pop(buf_pop), .bus_push(buf_push), .bus_byte(bus_rbyte),
        .host_pop(data_rd), .host_push(data_wr), .host_b0(b0), .host_b1(b1),
        .level(level), .head0(head0), .head1(head1)
    );

    i2cs_engine #(.CNT_W(CNT_W), .DEPTH(BUF_DEPTH)) u_eng (
        .clk(clk), .rst(rst), .soft_clr(soft_clr),
        .en(ctrl[C_EN]), .mst(ctrl[C_MST]), .start(ctrl[C_START]),
        .stop(ctrl[C_STOP]), .rpt(ctrl[C_RPT]), .tx(ctrl[C_TX]),
        .kick(kick), .abyte(addr_byte(saddr[6:0], ctrl[C_TX])),
        .prog_cnt(cnt_prog), .level(level), .head(head0),
        .bus_done(bus_done), .bus_nack(bus_nack),
        .bus_req(bus_req), .bus_start(bus_start), .bus_stop(bus_stop),
        .bus_rd(bus_rd), .bus_wbyte(bus_wbyte),
        .buf_pop(buf_pop), .buf_push(buf_push), .evt(evt),
        .cur_cnt(cur_cnt), .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            ctrl     <= '0;
            saddr    <= '0;
            cnt_prog <= '0;
            stat     <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl <= reg_wdata & CTRL_KEEP;
            end else begin
                if (evt.clr_start) ctrl[C_START] <= 1'b0;
                if (evt.clr_stop)  ctrl[C_STOP]  <= 1'b0;
                if (evt.clr_mst)   ctrl[C_MST]   <= 1'b0;
            end
            if (reg_wr && reg_addr == A_SADDR) saddr    <= reg_wdata[SADDR_W-1:0];
            if (reg_wr && reg_addr == A_COUNT) cnt_prog <= CNT_W'(reg_wdata);
            stat <= (stat & ~(stat_wr ? reg_wdata[STAT_W-1:0] : '0))
                  | (STAT_W'(evt.set_nack) << S_NACK)
                  | (STAT_W'(evt.set_ardy) << S_ARDY)
                  | (STAT_W'(evt.set_rrdy) << S_RRDY)
                  | (STAT_W'(evt.set_xrdy) << S_XRDY)
                  | (STAT_W'(data_rd && level == LVL_W'(1)) << S_SINGLE);
        end
    end

    always_comb begin
        stat_view         = stat;
        stat_view[S_BUSY] = busy;
        hi_b              = (level >= LVL_W'(2)) ? head1 : '0;
        unique case (reg_addr)
            A_CTRL:  reg_rdata = ctrl;
            A_SADDR: reg_rdata = REG_W'(saddr);
            A_COUNT: reg_rdata = REG_W'(cur_cnt);
            A_DATA:  reg_rdata = ctrl[C_SWAP] ? {head0, hi_b} : {hi_b, head0};
            A_STAT:  reg_rdata = REG_W'(stat_view);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker import i2cs_pkg::*; #(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              bus_req,
    input logic              bus_start,
    input logic              bus_stop,
    input logic              bus_done,
    input logic              bus_nack,
    input logic [BYTE_W-1:0] bus_wbyte,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic [CNT_W-1:0]  cnt_prog
);
    // R3
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !(bus_start && bus_stop));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_done |=> bus_req && $stable(bus_wbyte)
                                 && $stable(bus_start) && $stable(bus_stop));

    // R4
    addr_nack_release_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_start && bus_done && bus_nack |=> !bus_req);

    // R6
    stop_reload_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_stop && bus_done |=> cur_cnt == $past(cnt_prog));

    // R2
    disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr && reg_addr == A_CTRL && !reg_wdata[C_EN] |=> !bus_req && cur_cnt == '0);
endmodule

bind i2c_xfer_seq i2cs_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .bus_req(bus_req), .bus_start(bus_start), .bus_stop(bus_stop),
    .bus_done(bus_done), .bus_nack(bus_nack), .bus_wbyte(bus_wbyte),
    .cur_cnt(cur_cnt), .cnt_prog(cnt_prog)
);

// File: tb/i2c_xfer_seq_bench.sv
`timescale 1ns/1ps
module i2c_xfer_seq_bench;
    localparam logic [15:0] EN = 16'h8000, MST = 16'h0400, TXB = 16'h0200,
                            SWP = 16'h4000, RPT = 16'h0004, STP = 16'h0002, STT = 16'h0001;
    localparam logic [6:0]  SLV = 7'h3A;

    logic        clk = 1'b0, rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic        bus_req, bus_start, bus_stop, bus_rd, bus_done, bus_nack;
    logic [7:0]  bus_wbyte, bus_rbyte;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // slave model
    logic       sl_clr = 1'b0;
    int         nack_at = -1;
    int         n_tx, n_start, n_stop;
    logic [7:0] tx_log [16];
    logic [7:0] last_addr, rx_next;

    always #4 clk = ~clk;

    i2c_xfer_seq u_i2c_xfer_seq (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_req(bus_req), .bus_start(bus_start), .bus_stop(bus_stop), .bus_rd(bus_rd),
        .bus_wbyte(bus_wbyte), .bus_done(bus_done), .bus_nack(bus_nack), .bus_rbyte(bus_rbyte)
    );

    assign bus_nack  = bus_start ? (bus_wbyte[7:1] != SLV)
                                 : (!bus_rd && !bus_stop && n_tx == nack_at);
    assign bus_rbyte = rx_next;

    always @(posedge clk) begin
        if (rst || sl_clr) begin
            bus_done <= 1'b0; n_tx <= 0; n_start <= 0; n_stop <= 0;
            last_addr <= '0; rx_next <= 8'hA0;
        end else begin
            bus_done <= bus_req && !bus_done;
            if (bus_req && bus_done) begin
                if (bus_start) begin n_start <= n_start + 1; last_addr <= bus_wbyte; end
                else if (bus_stop) n_stop <= n_stop + 1;
                else if (!bus_rd) begin
                    if (n_tx < 16) tx_log[n_tx] <= bus_wbyte;
                    n_tx <= n_tx + 1;
                end else rx_next <= rx_next + 8'd1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (60) @(negedge clk);
    endtask

    task automatic fresh();
        wr(3'd0, 16'h0000);
        @(negedge clk); sl_clr = 1'b1; @(negedge clk); sl_clr = 1'b0;
        nack_at = -1;
        wr(3'd1, {6'h08, 3'b0, SLV});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  eb [4];
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        rd(3'd0, v); chk("R2 ctrl after reset", v, 0);
        rd(3'd2, v); chk("R2 count after reset", v, 0);
        rd(3'd4, v); chk("R2 status after reset", v, 0);

        // R1 mask
        fresh();
        wr(3'd0, 16'hFFFE); settle();
        rd(3'd0, v); chk("R1 ctrl mask", v, 16'hCF06);
        chk("R1 no start without start bit", n_start, 0);

        // R2 disable clears
        wr(3'd2, 16'd7); wr(3'd3, 16'h1234);
        wr(3'd0, 16'h0000);
        rd(3'd0, v); chk("R2 ctrl cleared", v, 0);
        rd(3'd1, v); chk("R2 saddr cleared", v, 0);
        wr(3'd0, EN | MST | TXB | STT); settle();
        rd(3'd2, v); chk("R2 count cleared", v, 0);
        chk("R2 buffer cleared", n_tx, 0);

        // R3 start without master
        fresh();
        wr(3'd0, EN | STT); settle();
        chk("R3 no request without master", n_start, 0);

        // R4 address nack
        fresh();
        wr(3'd1, 16'h0011); wr(3'd2, 16'd2); wr(3'd3, 16'hBBAA);
        wr(3'd0, EN | MST | TXB | STP | STT); settle();
        chk("R3 address phase count", n_start, 1);
        chk("R3 address byte tx", last_addr, {7'h11, 1'b0});
        chk("R4 no data on address nack", n_tx, 0);
        rd(3'd4, v); chk("R4 nack set, bus released", v & 16'h11, 16'h01);
        rd(3'd0, v); chk("R4 start and stop cleared", v, EN | MST | TXB);

        // R5 R6 count tx with stop, R10 order
        fresh();
        wr(3'd2, 16'd4); wr(3'd3, 16'h2211); wr(3'd3, 16'h4433);
        wr(3'd0, EN | MST | TXB | STP | STT); settle();
        chk("R10 byte order", {tx_log[0], tx_log[1], tx_log[2], tx_log[3]}, 32'h11223344);
        chk("R6 stop issued", n_stop, 1);
        rd(3'd2, v); chk("R6 count reloaded", v, 4);
        rd(3'd0, v); chk("R6 stop bit cleared", v, EN | MST | TXB);

        // R10 swap, R6 no stop
        fresh();
        wr(3'd0, EN | SWP); wr(3'd2, 16'd2); wr(3'd3, 16'h2211);
        wr(3'd0, EN | SWP | MST | TXB | STT); settle();
        chk("R10 swapped order", {tx_log[0], tx_log[1]}, 16'h2211);
        rd(3'd4, v); chk("R6 ardy and bus held", v & 16'h12, 16'h12);
        rd(3'd0, v); chk("R6 master cleared", v, EN | SWP | TXB);
        rd(3'd2, v); chk("R6 count zero", v, 0);

        // R11 overfill, R5 partial
        fresh();
        wr(3'd2, 16'd6);
        wr(3'd3, 16'h0201); wr(3'd3, 16'h0403); wr(3'd3, 16'h0605);
        wr(3'd0, EN | MST | TXB | STP | STT); settle();
        chk("R11 third write ignored", n_tx, 4);
        chk("R11 last byte sent", tx_log[3], 8'h04);
        rd(3'd2, v); chk("R5 remaining count", v, 2);
        rd(3'd4, v); chk("R5 xrdy set", v & 16'h08, 16'h08);
        chk("R5 no stop yet", n_stop, 0);

        // R7 data nack
        fresh();
        nack_at = 1;
        wr(3'd2, 16'd4); wr(3'd3, 16'h2211); wr(3'd3, 16'h4433);
        wr(3'd0, EN | MST | TXB | STP | STT); settle();
        chk("R7 sending stopped", n_tx, 2);
        chk("R7 no stop phase", n_stop, 0);
        rd(3'd4, v); chk("R7 nack status", v & 16'h01, 16'h01);
        rd(3'd0, v); chk("R7 stop cleared", v, EN | MST | TXB);

        // R8 count rx parked and resumed
        fresh();
        wr(3'd2, 16'd6);
        wr(3'd0, EN | MST | STT); settle();
        chk("R3 address byte rx", last_addr, {SLV, 1'b1});
        rd(3'd2, v); chk("R8 stops at full buffer", v, 2);
        rd(3'd4, v); chk("R8 rrdy set", v & 16'h06, 16'h04);
        rd(3'd3, v); chk("R10 read order", v, 16'hA1A0);
        settle();
        rd(3'd4, v); chk("R8 ardy after resume", v & 16'h02, 16'h02);
        rd(3'd3, v); chk("R8 data 2", v, 16'hA3A2);
        rd(3'd3, v); chk("R8 data 3", v, 16'hA5A4);

        // R10 single byte read
        fresh();
        wr(3'd2, 16'd3);
        wr(3'd0, EN | MST | STP | STT); settle();
        chk("R8 rx stop", n_stop, 1);
        rd(3'd3, v); chk("R10 first pair", v, 16'hA1A0);
        rd(3'd3, v); chk("R10 single byte", v, 16'h00A2);
        rd(3'd4, v); chk("R10 single flag", v & 16'h20, 16'h20);

        // R12 write one to clear
        wr(3'd4, 16'h0020);
        rd(3'd4, v); chk("R12 single cleared, rrdy kept", v & 16'h24, 16'h04);

        // R9 repeat tx
        fresh();
        wr(3'd2, 16'd5); wr(3'd3, 16'h2211); wr(3'd3, 16'h4433);
        wr(3'd0, EN | MST | TXB | RPT | STT); settle();
        chk("R9 repeat drained", n_tx, 4);
        rd(3'd2, v); chk("R9 count untouched", v, 5);
        rd(3'd4, v); chk("R9 xrdy, bus held", v & 16'h18, 16'h18);
        wr(3'd0, EN | MST | TXB | RPT | STP); settle();
        chk("R9 stop on request", n_stop, 1);
        rd(3'd4, v); chk("R9 bus released", v & 16'h10, 16'h00);

        // R9 repeat rx
        fresh();
        wr(3'd2, 16'd1);
        wr(3'd0, EN | MST | RPT | STT); settle();
        rd(3'd2, v); chk("R9 rx count untouched", v, 1);
        rd(3'd3, v); chk("R9 rx filled", v, 16'hA1A0);
        rd(3'd3, v); chk("R9 rx filled to four", v, 16'hA3A2);

        // random count-mode transmit
        for (int it = 0; it < 24; it++) begin
            int cnt, nw, lvl, sent;
            bit stp;
            cnt = $urandom_range(0, 5);
            nw  = $urandom_range(0, 2);
            stp = 1'($urandom_range(0, 1));
            fresh();
            wr(3'd2, 16'(cnt));
            for (int k = 0; k < nw; k++) begin
                eb[2*k]   = 8'($urandom);
                eb[2*k+1] = 8'($urandom);
                wr(3'd3, {eb[2*k+1], eb[2*k]});
            end
            lvl  = 2 * nw;
            sent = (cnt < lvl) ? cnt : lvl;
            wr(3'd0, EN | MST | TXB | STT | (stp ? STP : 16'h0)); settle();
            chk("R5 random bytes sent", n_tx, sent);
            for (int k = 0; k < sent; k++) chk("R5 random byte", tx_log[k], eb[k]);
            rd(3'd2, v);
            if (sent < cnt) begin
                chk("R5 random remaining", v, 16'(cnt - sent));
                chk("R5 random no stop", n_stop, 0);
            end else if (stp) begin
                chk("R6 random reload", v, 16'(cnt));
                chk("R6 random stop", n_stop, 1);
            end else begin
                chk("R6 random zero", v, 0);
                rd(3'd4, v); chk("R6 random ardy", v & 16'h02, 16'h02);
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule